// File: doc/BRIEF.md
# System Clock Source Switch Controller

This block picks the system clock from one of two sources: a free-running low-speed clock or a power-of-two division of a high-speed oscillator. Software drives it through a small register file clocked by the low-speed clock. Turning the high-speed oscillator on and choosing it as the system clock are separate controls. Software can therefore start the oscillator early, keep running from the low-speed clock while it settles, and move over later. Software can also request the switch at once, in which case the CPU is stalled until the oscillator is stable.

A stabilization counter runs on the raw oscillator from the moment the oscillator is enabled. Its length is a programmable count of oscillator cycles. The handover between sources never produces a short pulse: the outgoing source's gate closes on that clock's falling edge, and the incoming gate opens only after a two-flop synchronizer in the incoming domain has seen it. A low-voltage input keeps the divided high-speed clock at 1/4 or slower, which keeps a 16 MHz oscillator at 4 MHz or below. When software drops the oscillator enable while the high-speed clock is in use, the block first moves back to the low-speed clock and only then stops the oscillator.

The register interface has no data stream and no back-pressure. A write is taken on any low-speed rising edge with `wr_en` high. Reads are combinational from `rd_addr`.

Top module: `clk_source_switch`

## Requirements
- R1: After reset all registers read 0, `osc_run` and `cpu_wait` are low, and `sys_clk` follows the low-speed clock.
- R2: Address 0 holds bit 1 = oscillator enable and bit 0 = source select. The value 0x02 runs the oscillator and stays on the low-speed clock. The value 0x03 selects the high-speed clock. Address 1 holds the wait code in bits [1:0]. Address 2 holds the divider code in bits [2:0]. Address 3 is read-only status, with bit 0 = oscillator stable and bit 1 = high-speed clock driving `sys_clk`. Writes to address 3 are ignored, and unused bits read 0.
- R3: The stable flag rises about 256·2^wait_code oscillator cycles after the enable bit rises. The high-speed clock never drives `sys_clk` unless the stable flag is set.
- R4: While the control register holds 0x03 and the oscillator is not yet stable, `cpu_wait` is high. It falls once the stable flag is set, and the switch to the high-speed clock follows.
- R5: Writing 0x03 after the oscillator is already stable switches the clock without raising `cpu_wait`.
- R6: Neither source gate is ever open at the same time as the other, and `sys_clk` never shows a pulse shorter than a half period of the active source.
- R7: Divider codes 0 to 5 give a ratio of 1/2^code. Codes 6 and 7 give 1/32.
- R8: While `lv_mode` is high, any divider code below 2 behaves as code 2 (1/4).
- R9: Clearing the enable bit while the high-speed clock is in use (writing 0x00, or 0x01) returns `sys_clk` to the low-speed clock, then stops the oscillator and clears the stable flag. The select bit has no effect while the enable bit is 0.
- R10: `osc_run` follows the enable bit, except that it stays high for as long as the high-speed clock still drives `sys_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lsclk | input | 1 | Low-speed clock; also clocks the register file |
| hsclk | input | 1 | Raw high-speed oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lv_mode | input | 1 | Low-voltage mode; limits the divider to 1/4 or slower |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data for `rd_addr` |
| osc_run | output | 1 | Enable to the high-speed oscillator |
| cpu_wait | output | 1 | CPU stall request |
| sys_clk | output | 1 | Selected system clock |

## Verification
The hardest situation to reach is a handover in either direction at an extreme divider ratio (1/1 or 1/32). At those ratios the two synchronizers run at very different speeds, and a short pulse or an overlapping gate would appear at the seam. The stimulus visits every divider code, with and without the low-voltage clamp. Each case alternates between the stalled path (0x03 written from off) and the pre-enabled path (0x02, then 0x03), and turns the oscillator off with 0x00 or 0x01. A monitor measures every `sys_clk` pulse width across all of these handovers.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_WAIT = 2'd1;
  localparam logic [1:0] A_DIV  = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  typedef struct packed {
    logic hs_active;
    logic stable;
  } clk_status_t;

  // effective log2 of the divide ratio: reserved codes saturate, low voltage floors
  function automatic int unsigned eff_div_log2(input int unsigned code, input logic lv,
                                               input int unsigned max_log2,
                                               input int unsigned lv_min);
    int unsigned k;
    k = (code > max_log2) ? max_log2 : code;
    if (lv && (k < lv_min)) k = lv_min;
    return k;
  endfunction
endpackage

// File: rtl/clksw_sync.sv
module clksw_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clksw_regs.sv
module clksw_regs
  import clksw_pkg::*;
#(
  parameter int WAIT_SEL_W = 2,
  parameter int DIV_SEL_W  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [1:0]            wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [1:0]            rd_addr,
  input  clk_status_t           status,
  output logic                  osc_en,
  output logic                  src_sel,
  output logic [WAIT_SEL_W-1:0] wait_code,
  output logic [DIV_SEL_W-1:0]  div_code,
  output logic [7:0]            rd_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_en    <= 1'b0;
      src_sel   <= 1'b0;
      wait_code <= '0;
      div_code  <= '0;
    end else if (wr_en) begin
      unique case (wr_addr)
        A_CTRL: begin
          osc_en  <= wr_data[1];
          src_sel <= wr_data[0];
        end
        A_WAIT:  wait_code <= wr_data[WAIT_SEL_W-1:0];
        A_DIV:   div_code  <= wr_data[DIV_SEL_W-1:0];
        default: ;  // status is read-only
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      A_CTRL:  rd_data[1:0] = {osc_en, src_sel};
      A_WAIT:  rd_data[WAIT_SEL_W-1:0] = wait_code;
      A_DIV:   rd_data[DIV_SEL_W-1:0] = div_code;
      default: rd_data[1:0] = status;
    endcase
  end
endmodule

// File: rtl/clksw_stab.sv
module clksw_stab #(
  parameter int WAIT_BASE_LOG2 = 8,
  parameter int WAIT_SEL_W     = 2,
  parameter int SYNC_STAGES    = 2
) (
  input  logic                  hsclk,
  input  logic                  rst_n,
  input  logic                  osc_on,
  input  logic [WAIT_SEL_W-1:0] wait_code,
  output logic                  stable
);
  localparam int CNT_W = WAIT_BASE_LOG2 + (1 << WAIT_SEL_W) - 1;

  logic             on_hs;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  clksw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_on_sync (
    .clk(hsclk), .rst_n(rst_n), .d(osc_on), .q(on_hs)
  );

  // wait_code is set before the oscillator starts, so it is quasi-static here
  always_comb last = (CNT_W'(1) << (WAIT_BASE_LOG2 + int'(wait_code))) - CNT_W'(1);

  always_ff @(posedge hsclk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      stable <= 1'b0;
    end else if (!on_hs) begin
      cnt    <= '0;
      stable <= 1'b0;
    end else if (!stable) begin
      if (cnt == last) stable <= 1'b1;
      else             cnt    <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/clksw_div.sv
module clksw_div
  import clksw_pkg::*;
#(
  parameter int DIV_SEL_W    = 3,
  parameter int DIV_MAX_LOG2 = 5,
  parameter int LV_MIN_LOG2  = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                 hsclk,
  input  logic                 rst_n,
  input  logic                 lv_mode,
  input  logic [DIV_SEL_W-1:0] div_code,
  output logic                 div_clk
);
  localparam int TAP_W = DIV_MAX_LOG2 + 1;
  localparam int SEL_W = $clog2(TAP_W);

  logic [DIV_MAX_LOG2-1:0] cnt;
  logic [TAP_W-1:0]        taps;
  logic [SEL_W-1:0]        tap_sel;
  logic                    lv_hs;

  clksw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_lv_sync (
    .clk(hsclk), .rst_n(rst_n), .d(lv_mode), .q(lv_hs)
  );

  always_ff @(posedge hsclk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  assign taps[0] = hsclk;
  for (genvar i = 0; i < DIV_MAX_LOG2; i++) begin : g_tap
    assign taps[i+1] = cnt[i];
  end

  always_comb
    tap_sel = SEL_W'(eff_div_log2(32'(div_code), lv_hs, DIV_MAX_LOG2, LV_MIN_LOG2));

  assign div_clk = taps[tap_sel];
endmodule

// File: rtl/clksw_gfmux.sv
module clksw_gfmux #(
  parameter int SYNC_STAGES = 2
) (
  input  logic lsclk,
  input  logic hs_clk,
  input  logic rst_n,
  input  logic to_hs,
  output logic ls_gate,
  output logic hs_gate,
  output logic sys_clk
);
  logic ls_go;
  logic hs_go;

  clksw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ls_sync (
    .clk(lsclk), .rst_n(rst_n), .d(~to_hs & ~hs_gate), .q(ls_go)
  );

  clksw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_hs_sync (
    .clk(hs_clk), .rst_n(rst_n), .d(to_hs & ~ls_gate), .q(hs_go)
  );

  // gates change only while their own clock is low
  always_ff @(negedge lsclk or negedge rst_n) begin
    if (!rst_n) ls_gate <= 1'b1;
    else        ls_gate <= ls_go;
  end

  always_ff @(negedge hs_clk or negedge rst_n) begin
    if (!rst_n) hs_gate <= 1'b0;
    else        hs_gate <= hs_go;
  end

  assign sys_clk = (lsclk & ls_gate) | (hs_clk & hs_gate);
endmodule

// File: rtl/clk_source_switch.sv
module clk_source_switch
  import clksw_pkg::*;
#(
  parameter int WAIT_BASE_LOG2 = 8,
  parameter int WAIT_SEL_W     = 2,
  parameter int DIV_SEL_W      = 3,
  parameter int DIV_MAX_LOG2   = 5,
  parameter int LV_MIN_LOG2    = 2,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       lsclk,
  input  logic       hsclk,
  input  logic       rst_n,
  input  logic       lv_mode,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       osc_run,
  output logic       cpu_wait,
  output logic       sys_clk
);
  logic                  osc_en;
  logic                  src_sel;
  logic [WAIT_SEL_W-1:0] wait_code;
  logic [DIV_SEL_W-1:0]  div_code;
  logic                  stable_hs;
  logic                  stable_ls;
  logic                  hs_ls;
  logic                  hs_div_clk;
  logic                  ls_gate;
  logic                  hs_gate;
  logic                  want_hs;
  logic                  to_hs;
  clk_status_t           status;

  assign status  = '{hs_active: hs_ls, stable: stable_ls};
  assign want_hs = osc_en & src_sel;
  assign to_hs   = want_hs & stable_ls;
  assign cpu_wait = want_hs & ~stable_ls;
  // oscillator keeps running until the low-speed gate is open again
  assign osc_run = osc_en | ~ls_gate;

  clksw_regs #(.WAIT_SEL_W(WAIT_SEL_W), .DIV_SEL_W(DIV_SEL_W)) u_regs (
    .clk(lsclk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .status(status), .osc_en(osc_en), .src_sel(src_sel),
    .wait_code(wait_code), .div_code(div_code), .rd_data(rd_data)
  );

  clksw_stab #(.WAIT_BASE_LOG2(WAIT_BASE_LOG2), .WAIT_SEL_W(WAIT_SEL_W),
               .SYNC_STAGES(SYNC_STAGES)) u_stab (
    .hsclk(hsclk), .rst_n(rst_n), .osc_on(osc_run), .wait_code(wait_code),
    .stable(stable_hs)
  );

  clksw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_stable_sync (
    .clk(lsclk), .rst_n(rst_n), .d(stable_hs), .q(stable_ls)
  );

  clksw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_active_sync (
    .clk(lsclk), .rst_n(rst_n), .d(hs_gate), .q(hs_ls)
  );

  clksw_div #(.DIV_SEL_W(DIV_SEL_W), .DIV_MAX_LOG2(DIV_MAX_LOG2),
              .LV_MIN_LOG2(LV_MIN_LOG2), .SYNC_STAGES(SYNC_STAGES)) u_div (
    .hsclk(hsclk), .rst_n(rst_n), .lv_mode(lv_mode), .div_code(div_code),
    .div_clk(hs_div_clk)
  );

  clksw_gfmux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
    .lsclk(lsclk), .hs_clk(hs_div_clk), .rst_n(rst_n), .to_hs(to_hs),
    .ls_gate(ls_gate), .hs_gate(hs_gate), .sys_clk(sys_clk)
  );
endmodule

// File: rtl/clksw_checks.sv
module clksw_checks (
  input logic lsclk,
  input logic rst_n,
  input logic ls_gate,
  input logic hs_gate,
  input logic stat_stable,
  input logic stat_hs,
  input logic cpu_wait,
  input logic osc_run
);
  AST_ONE_SOURCE: assert property (@(posedge lsclk) disable iff (!rst_n)
    $countones({ls_gate, hs_gate}) <= 1); // R6

  AST_HS_NEEDS_STABLE: assert property (@(posedge lsclk) disable iff (!rst_n)
    stat_hs |-> stat_stable); // R3

  AST_NO_STALL_ON_HS: assert property (@(posedge lsclk) disable iff (!rst_n)
    cpu_wait |-> !stat_hs); // R4

  AST_OSC_KEPT: assert property (@(posedge lsclk) disable iff (!rst_n)
    hs_gate |-> osc_run); // R10
endmodule

bind clk_source_switch clksw_checks u_checks (
  .lsclk(lsclk), .rst_n(rst_n), .ls_gate(ls_gate), .hs_gate(hs_gate),
  .stat_stable(stable_ls), .stat_hs(hs_ls), .cpu_wait(cpu_wait), .osc_run(osc_run)
);

// File: tb/test_clk_source_switch.sv
`timescale 1ns/1ps
module test_clk_source_switch;
  logic       lsclk = 1'b0;
  logic       hsclk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lv_mode = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       osc_run;
  logic       cpu_wait;
  logic       sys_clk;

  localparam real LS_PER = 8.0;  // 125 MHz
  localparam real HS_PER = 2.0;

  always #4 lsclk = ~lsclk;
  always #1 hsclk = ~hsclk;

  clk_source_switch i_clk_source_switch (
    .lsclk(lsclk), .hsclk(hsclk), .rst_n(rst_n), .lv_mode(lv_mode),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .osc_run(osc_run), .cpu_wait(cpu_wait), .sys_clk(sys_clk)
  );

  int  n_checks = 0;
  int  n_fails = 0;
  int  glitches = 0;
  bit  mon_on = 1'b0;
  bit  finished = 1'b0;
  real t_rise = 0.0;
  real t_fall = 0.0;

  always @(posedge sys_clk) begin
    if (mon_on && ($realtime - t_fall) < 0.9) glitches++;
    t_rise = $realtime;
  end
  always @(negedge sys_clk) begin
    if (mon_on && ($realtime - t_rise) < 0.9) glitches++;
    t_fall = $realtime;
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_range(input string req, input string what, input real act,
                           input real lo, input real hi);
    n_checks++;
    if (act < lo || act > hi) begin
      n_fails++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f..%0.3f", req, what, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge lsclk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge lsclk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge lsclk);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic period(output real p);
    real t0;
    @(posedge sys_clk);
    @(posedge sys_clk);
    t0 = $realtime;
    @(posedge sys_clk);
    p = $realtime - t0;
  endtask

  task automatic wait_status(input logic [1:0] want, input int maxc, output logic [1:0] got);
    logic [7:0] v;
    v = '0;
    for (int i = 0; i < maxc; i++) begin
      rd(2'd3, v);
      if (v[1:0] == want) break;
    end
    got = v[1:0];
  endtask

  function automatic int exp_log2(input int code, input bit lv);
    int k;
    k = (code > 5) ? 5 : code;
    if (lv && k < 2) k = 2;
    return k;
  endfunction

  function automatic int stall_cycles(input int w);
    return 256 << w;
  endfunction

  task automatic run_case(input int w, input int d, input bit lv, input bit pre, input bit off01);
    logic [1:0] st;
    real        p;
    real        lim_ns;
    int         n;
    bit         saw_wait;
    string      tag;
    tag = $sformatf("w%0d d%0d lv%0d pre%0d", w, d, lv, pre);
    lv_mode = lv;
    wr(2'd1, 8'(w));
    wr(2'd2, 8'(d));
    lim_ns = stall_cycles(w) * HS_PER;
    if (!pre) begin
      wr(2'd0, 8'h03);
      chk("R4", {"stall raised ", tag}, cpu_wait, 1);
      chk("R10", {"osc_run on ", tag}, osc_run, 1);
      n = 0;
      while (cpu_wait && n < 4000) begin
        @(negedge lsclk);
        n++;
      end
      chk_range("R3", {"stall length ns ", tag}, (n + 0.5) * LS_PER, lim_ns - LS_PER, lim_ns + 64.0);
    end else begin
      wr(2'd0, 8'h02);
      repeat (int'(lim_ns / LS_PER) + 12) @(negedge lsclk);
      wait_status(2'b01, 4, st);
      chk("R2", {"stable on low-speed ", tag}, st, 2'b01);
      period(p);
      chk_range("R2", {"still low-speed period ", tag}, p, LS_PER - 0.01, LS_PER + 0.01);
      wr(2'd0, 8'h03);
      saw_wait = cpu_wait;
      repeat (10) begin
        @(negedge lsclk);
        saw_wait |= cpu_wait;
      end
      chk("R5", {"no stall when stable ", tag}, saw_wait, 0);
    end
    wait_status(2'b11, 100, st);
    chk("R3", {"status high-speed ", tag}, st, 2'b11);
    period(p);
    chk_range((lv && d < 2) ? "R8" : "R7", {"divided period ", tag}, p,
              HS_PER * (1 << exp_log2(d, lv)) - 0.01, HS_PER * (1 << exp_log2(d, lv)) + 0.01);
    wr(2'd0, off01 ? 8'h01 : 8'h00);
    chk("R10", {"osc held during return ", tag}, osc_run, 1);
    wait_status(2'b00, 100, st);
    chk("R9", {"status cleared ", tag}, st, 2'b00);
    chk("R9", {"osc stopped ", tag}, osc_run, 0);
    period(p);
    chk_range("R9", {"back to low-speed ", tag}, p, LS_PER - 0.01, LS_PER + 0.01);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
  endtask

  initial begin
    #1_200_000;
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [1:0] st;
    real        p;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge lsclk);
    rst_n = 1'b1;
    repeat (2) @(negedge lsclk);
    mon_on = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R1", $sformatf("reset read addr %0d", a), v, 0);
    end
    chk("R1", "osc_run after reset", osc_run, 0);
    chk("R1", "cpu_wait after reset", cpu_wait, 0);
    period(p);
    chk_range("R1", "reset period", p, LS_PER - 0.01, LS_PER + 0.01);

    // R2 field masking and read-only status
    wr(2'd2, 8'hFF); rd(2'd2, v); chk("R2", "divider field mask", v, 8'h07);
    wr(2'd1, 8'hFF); rd(2'd1, v); chk("R2", "wait field mask", v, 8'h03);
    wr(2'd0, 8'hFC); rd(2'd0, v); chk("R2", "control field mask", v, 8'h00);
    wr(2'd3, 8'hFF); rd(2'd3, v); chk("R2", "status write ignored", v, 8'h00);
    wr(2'd1, 8'h00); wr(2'd2, 8'h00);

    // R9 select without enable does nothing
    wr(2'd0, 8'h01);
    repeat (40) @(negedge lsclk);
    chk("R9", "select alone keeps osc off", osc_run, 0);
    chk("R9", "select alone no stall", cpu_wait, 0);
    wait_status(2'b00, 2, st);
    chk("R9", "select alone status", st, 2'b00);
    wr(2'd0, 8'h00);

    // directed: every divider code, both paths
    for (int d = 0; d < 8; d++) run_case(0, d, 1'b0, d[0], d[1]);
    // directed: low-voltage clamp at the small codes, longest wait once
    for (int d = 0; d < 4; d++) run_case((d == 3) ? 3 : 1, d, 1'b1, d[0], ~d[0]);
    // constrained random
    for (int i = 0; i < 8; i++)
      run_case(int'($urandom_range(2, 0)), int'($urandom_range(7, 0)),
               1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)));

    mon_on = 1'b0;
    chk("R6", "short pulses on sys_clk", glitches, 0);
    finished = 1'b1;
    report();
    $finish;
  end
endmodule